// File: doc/BRIEF.md
# Sampling Memory Bank Freeze Controller

This block is the digital controller of a switched-capacitor sampling memory that is split into a ring of banks. Each bank clock moves a write pointer to the next bank, so the analog input is recorded without a break. When a level-1 trigger arrives, the controller takes a run of consecutive banks that lie a fixed latency behind the write pointer. These banks hold the triggered event, and the controller freezes them by queueing a bank mask in a small freeze queue. The write pointer then steps over every frozen bank.

The read side always works on the oldest queued event. After a read request, it presents that event's banks one at a time, starting with the earliest written, and moves to the next bank on each acknowledge. It flags the last bank of the event. Acknowledging the last bank drops the event from the queue and returns its banks to the writer, while sampling carries on. A build option starts readout on its own whenever an event is waiting. When the queue is full, new triggers are dropped and a sticky flag records the loss. If no free bank is left, the writer halts and reports a stall until a group is released.

Top module: `bank_freeze_ctrl`

## Requirements
- R1: After reset the write bank is 0 and the stall, busy, overflow, read-valid and end-of-event outputs are all 0.
- R2: With no frozen banks ahead, the write bank advances by one per clock, modulo NB, and wraps from NB-1 to 0.
- R3: A trigger sampled while the write bank is w freezes the X banks (w-LAT-X+1) mod NB through (w-LAT) mod NB as one queue entry.
- R4: The write bank never takes a frozen bank, including a bank frozen by a trigger accepted on the same clock edge. The writer moves to the next free bank in increasing index order.
- R5: busy is 1 exactly while the queue holds NF entries.
- R6: A trigger that arrives while the queue is full is dropped and adds no entry. It sets the overflow flag, which stays at 1 until reset.
- R7: A read request with a non-empty queue sets read-valid on the next clock. The read bank is then the oldest bank of the oldest entry, and each acknowledge moves it to the next bank of that entry, modulo NB.
- R8: End-of-event is 1 while the last bank of the entry is presented. Acknowledging it clears read-valid, removes the entry, and makes its banks writable again.
- R9: When every bank other than the write bank is frozen, stall is 1 and the write bank holds. Once an entry is released, stall falls and writing resumes.
- R10: With AUTO_READ set, readout of a waiting entry starts without a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Level-1 trigger, one pulse per event |
| rd_req_i | input | 1 | Request to start reading the oldest event |
| rd_ack_i | input | 1 | Acknowledge of the presented read bank |
| wr_bank_o | output | BW | Bank currently being written |
| stall_o | output | 1 | No free bank to advance into |
| rd_valid_o | output | 1 | Read bank is valid |
| rd_bank_o | output | BW | Bank to be read |
| eoe_o | output | 1 | Presented bank is the last of its event |
| busy_o | output | 1 | Freeze queue full |
| ovf_o | output | 1 | Sticky trigger-lost flag |

## Verification
A corrupted queue entry or skip mask shows on the next clock. The write bank then lands on a bank the bench expects to be frozen, or it passes over a bank that should be free. A wrong shift on release appears as a wrong read bank on the next request. Read-index faults show as a bank or end-of-event mismatch one acknowledge later. An error in the occupancy count first shows as busy or overflow asserting at the wrong trigger, or as a missing or extra event during readout.

// File: rtl/bank_freeze_ctrl.sv
module bank_freeze_ctrl #(
  parameter int NB = 7,
  parameter int NF = 3,
  parameter int X = 2,
  parameter int LAT = 1,
  parameter int AUTO_READ = 0,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_i,
  input  logic          rd_req_i,
  input  logic          rd_ack_i,
  output logic [BW-1:0] wr_bank_o,
  output logic          stall_o,
  output logic          rd_valid_o,
  output logic [BW-1:0] rd_bank_o,
  output logic          eoe_o,
  output logic          busy_o,
  output logic          ovf_o
);
  localparam int CW = $clog2(NF + 1);
  localparam int IW = (X > 1) ? $clog2(X) : 1;

  function automatic logic [BW-1:0] wrap(input int v);
    return BW'(v % NB);
  endfunction

  logic [BW-1:0] wp_q, wp_d;
  logic [NB-1:0] mask_q [NF];
  logic [NB-1:0] mask_d [NF];
  logic [BW-1:0] head_q [NF];
  logic [BW-1:0] head_d [NF];
  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q;
  logic [IW-1:0] idx_q;
  logic          ovf_q;

  logic [NB-1:0] skip_w, win_mask, avoid;
  logic [BW-1:0] win_base;
  logic          push, pop, last_rd, begin_rd, free_any, free_eff;

  always_comb begin
    skip_w = '0;
    for (int i = 0; i < NF; i++)
      if (i < int'(cnt_q)) skip_w = skip_w | mask_q[i];
  end

  always_comb begin
    win_base = wrap(int'(wp_q) + 2 * NB - LAT - X + 1);
    win_mask = '0;
    for (int j = 0; j < X; j++) win_mask[wrap(int'(win_base) + j)] = 1'b1;
  end

  assign push     = trig_i && (cnt_q != CW'(NF));
  assign last_rd  = act_q && (idx_q == IW'(X - 1));
  assign pop      = last_rd && rd_ack_i;
  assign begin_rd = !act_q && (cnt_q != '0) && (rd_req_i || (AUTO_READ != 0));
  assign avoid    = skip_w | (push ? win_mask : '0);

  always_comb begin
    wp_d     = wp_q;
    free_any = 1'b0;
    free_eff = 1'b0;
    for (int k = 1; k < NB; k++) begin
      if (!skip_w[wrap(int'(wp_q) + k)]) free_any = 1'b1;
      if (!free_eff && !avoid[wrap(int'(wp_q) + k)]) begin
        wp_d     = wrap(int'(wp_q) + k);
        free_eff = 1'b1;
      end
    end
  end

  always_comb begin
    int slot;
    for (int i = 0; i < NF; i++) begin
      mask_d[i] = mask_q[i];
      head_d[i] = head_q[i];
    end
    if (pop) begin
      for (int i = 0; i < NF - 1; i++) begin
        mask_d[i] = mask_q[i+1];
        head_d[i] = head_q[i+1];
      end
      mask_d[NF-1] = '0;
      head_d[NF-1] = '0;
    end
    slot = int'(cnt_q) - (pop ? 1 : 0);
    if (push)
      for (int i = 0; i < NF; i++)
        if (i == slot) begin
          mask_d[i] = win_mask;
          head_d[i] = win_base;
        end
    cnt_d = CW'(int'(cnt_q) + (push ? 1 : 0) - (pop ? 1 : 0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
      idx_q <= '0;
      ovf_q <= 1'b0;
      for (int i = 0; i < NF; i++) begin
        mask_q[i] <= '0;
        head_q[i] <= '0;
      end
    end else begin
      wp_q  <= wp_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_q | (trig_i && !push);
      for (int i = 0; i < NF; i++) begin
        mask_q[i] <= mask_d[i];
        head_q[i] <= head_d[i];
      end
      if (act_q) begin
        if (rd_ack_i) begin
          if (last_rd) begin
            act_q <= 1'b0;
            idx_q <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
      end else if (begin_rd) begin
        act_q <= 1'b1;
        idx_q <= '0;
      end
    end
  end

  assign wr_bank_o  = wp_q;
  assign stall_o    = !free_any;
  assign rd_valid_o = act_q;
  assign rd_bank_o  = wrap(int'(head_q[0]) + int'(idx_q));
  assign eoe_o      = last_rd;
  assign busy_o     = (cnt_q == CW'(NF));
  assign ovf_o      = ovf_q;
endmodule

// File: rtl/bank_freeze_ctrl_chk.sv
module bank_freeze_ctrl_chk #(
  parameter int NB = 7,
  parameter int BW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trig,
  input logic          rd_ack,
  input logic [BW-1:0] wr_bank,
  input logic          stall,
  input logic          rd_valid,
  input logic [BW-1:0] rd_bank,
  input logic          eoe,
  input logic          busy,
  input logic          ovf,
  input logic [NB-1:0] skip
);
  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !trig) |=> (wr_bank != $past(wr_bank)));
  a_r4_wp_free: assert property (@(posedge clk) disable iff (!rst_n)
    !skip[wr_bank]);
  a_r6_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && busy) |=> ovf);
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  a_r7_hold_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ack) |=> (rd_valid && $stable(rd_bank)));
  a_r8_eoe_valid: assert property (@(posedge clk) disable iff (!rst_n)
    eoe |-> rd_valid);
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (wr_bank == $past(wr_bank)));
endmodule

bind bank_freeze_ctrl bank_freeze_ctrl_chk #(.NB(NB), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig_i), .rd_ack(rd_ack_i),
  .wr_bank(wr_bank_o), .stall(stall_o), .rd_valid(rd_valid_o),
  .rd_bank(rd_bank_o), .eoe(eoe_o), .busy(busy_o), .ovf(ovf_o), .skip(skip_w));

// File: tb/bank_freeze_ctrl_bench.sv
module bank_freeze_ctrl_bench;
  localparam int NB = 7, NF = 3, X = 2, LAT = 1, BW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0, rd_req = 1'b0, rd_ack = 1'b0;
  logic a_trig = 1'b0;
  logic [BW-1:0] wr_bank, rd_bank, a_wr_bank, a_rd_bank;
  logic stall, rd_valid, eoe, busy, ovf;
  logic a_stall, a_rd_valid, a_eoe, a_busy, a_ovf;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  bank_freeze_ctrl #(.NB(NB), .NF(NF), .X(X), .LAT(LAT), .AUTO_READ(0)) u_bank_freeze_ctrl (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .rd_req_i(rd_req), .rd_ack_i(rd_ack),
    .wr_bank_o(wr_bank), .stall_o(stall), .rd_valid_o(rd_valid), .rd_bank_o(rd_bank),
    .eoe_o(eoe), .busy_o(busy), .ovf_o(ovf));

  bank_freeze_ctrl #(.NB(NB), .NF(NF), .X(X), .LAT(LAT), .AUTO_READ(1)) u_bank_freeze_ctrl_auto (
    .clk(clk), .rst_n(rst_n), .trig_i(a_trig), .rd_req_i(1'b0), .rd_ack_i(1'b0),
    .wr_bank_o(a_wr_bank), .stall_o(a_stall), .rd_valid_o(a_rd_valid), .rd_bank_o(a_rd_bank),
    .eoe_o(a_eoe), .busy_o(a_busy), .ovf_o(a_ovf));

  // behavioural reference built from the requirements
  int m_wp, m_cnt, m_idx;
  bit m_act, m_ovf;
  bit [NB-1:0] m_mask [NF];
  int m_head [NF];

  function automatic bit [NB-1:0] m_skip();
    bit [NB-1:0] s = '0;
    for (int i = 0; i < NF; i++) if (i < m_cnt) s |= m_mask[i];
    return s;
  endfunction

  function automatic bit m_stall();
    bit [NB-1:0] s = m_skip();
    for (int k = 1; k < NB; k++) if (!s[(m_wp + k) % NB]) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wp = 0; m_cnt = 0; m_idx = 0; m_act = 0; m_ovf = 0;
      for (int i = 0; i < NF; i++) begin m_mask[i] = '0; m_head[i] = 0; end
    end else begin
      bit [NB-1:0] s, wm, av;
      bit push, pop, found;
      int base, nw;
      s = m_skip();
      push = trig && (m_cnt < NF);
      pop = m_act && rd_ack && (m_idx == X - 1);
      base = (m_wp + 2 * NB - LAT - X + 1) % NB;
      wm = '0;
      for (int j = 0; j < X; j++) wm[(base + j) % NB] = 1'b1;
      av = s | (push ? wm : '0);
      nw = m_wp; found = 0;
      for (int k = 1; k < NB; k++)
        if (!found && !av[(m_wp + k) % NB]) begin nw = (m_wp + k) % NB; found = 1; end
      if (trig && !push) m_ovf = 1;
      if (m_act) begin
        if (rd_ack) begin
          if (m_idx == X - 1) begin m_act = 0; m_idx = 0; end
          else m_idx++;
        end
      end else if (m_cnt > 0 && rd_req) begin
        m_act = 1; m_idx = 0;
      end
      if (pop) begin
        for (int i = 0; i < NF - 1; i++) begin m_mask[i] = m_mask[i+1]; m_head[i] = m_head[i+1]; end
        m_mask[NF-1] = '0;
        m_cnt--;
      end
      if (push) begin m_mask[m_cnt] = wm; m_head[m_cnt] = base; m_cnt++; end
      m_wp = nw;
    end
  end

  task automatic cmp(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cmp_all(string tag);
    cmp({tag, " wr_bank"}, wr_bank, m_wp);
    cmp({tag, " stall"}, stall, m_stall());
    cmp({tag, " busy"}, busy, m_cnt == NF);
    cmp({tag, " ovf"}, ovf, m_ovf);
    cmp({tag, " rd_valid"}, rd_valid, m_act);
    if (m_act) begin
      cmp({tag, " rd_bank"}, rd_bank, (m_head[0] + m_idx) % NB);
      cmp({tag, " eoe"}, eoe, m_idx == X - 1);
    end
  endtask

  task automatic step(string tag);
    @(negedge clk);
    cmp_all(tag);
  endtask

  task automatic t_reset();
    cmp("R1 wr_bank", wr_bank, 0);
    cmp("R1 flags", {stall, busy, ovf, rd_valid, eoe}, 0);
  endtask

  task automatic t_advance();
    int prev;
    bit wrapped = 0;
    for (int n = 0; n < NB + 2; n++) begin
      prev = wr_bank;
      step("R2");
      cmp("R2 plus one", wr_bank, (prev + 1) % NB);
      if (prev == NB - 1 && wr_bank == 0) wrapped = 1;
    end
    cmp("R2 wrap seen", wrapped, 1);
  endtask

  task automatic t_single();
    int w, base;
    bit hit = 0;
    w = wr_bank;
    base = (w + 2 * NB - LAT - X + 1) % NB;
    trig = 1; step("R3 trig"); trig = 0;
    for (int n = 0; n < NB; n++) begin
      step("R4 skip");
      for (int j = 0; j < X; j++) if (wr_bank == (base + j) % NB) hit = 1;
    end
    cmp("R4 frozen never written", hit, 0);
    rd_req = 1; step("R7 req"); rd_req = 0;
    cmp("R7 valid", rd_valid, 1);
    cmp("R3 first bank", rd_bank, base);
    cmp("R8 not last", eoe, 0);
    rd_ack = 1; step("R7 ack"); rd_ack = 0;
    cmp("R3 second bank", rd_bank, (base + 1) % NB);
    cmp("R8 last flagged", eoe, 1);
    step("R7 hold");
    cmp("R7 held bank", rd_bank, (base + 1) % NB);
    rd_ack = 1; step("R8 release"); rd_ack = 0;
    cmp("R8 valid drops", rd_valid, 0);
    hit = 0;
    for (int n = 0; n < NB; n++) begin
      step("R8 reuse");
      if (wr_bank == base) hit = 1;
    end
    cmp("R8 bank writable again", hit, 1);
    rd_req = 1; step("R7 empty req"); rd_req = 0;
    step("R7 empty");
    cmp("R7 no read when empty", rd_valid, 0);
  endtask

  task automatic t_full_stall();
    int w, held;
    w = wr_bank;
    trig = 1; step("R5 t1"); trig = 0; step("R5 gap");
    trig = 1; step("R5 t2"); trig = 0; step("R5 gap");
    cmp("R5 not busy at two", busy, 0);
    trig = 1; step("R5 t3"); trig = 0;
    cmp("R5 busy at full", busy, 1);
    cmp("R9 stall", stall, 1);
    held = wr_bank;
    cmp("R4 held on unfrozen bank", held, (w + 4) % NB);
    step("R9 hold"); step("R9 hold");
    cmp("R9 bank held", wr_bank, held);
    cmp("R6 no ovf yet", ovf, 0);
    trig = 1; step("R6 drop"); trig = 0;
    cmp("R6 ovf set", ovf, 1);
    rd_req = 1; step("R7 req"); rd_req = 0;
    cmp("R7 oldest first", rd_bank, (w + 2 * NB - 2) % NB);
    rd_ack = 1; step("R7 a"); step("R8 pop"); rd_ack = 0;
    cmp("R5 busy clears", busy, 0);
    cmp("R9 stall clears", stall, 0);
    step("R9 resume");
    cmp("R9 writer moved", wr_bank != held, 1);
    for (int e = 0; e < 2; e++) begin
      rd_req = 1; step("R7 req"); rd_req = 0;
      if (e == 0) cmp("R7 second entry", rd_bank, w);
      rd_ack = 1; step("R7 a"); step("R8 pop"); rd_ack = 0;
    end
    rd_req = 1; step("R6 req"); rd_req = 0; step("R6 idle");
    cmp("R6 dropped trigger added nothing", rd_valid, 0);
    cmp("R6 ovf sticky", ovf, 1);
  endtask

  task automatic t_auto();
    int w;
    @(negedge clk);
    w = a_wr_bank;
    a_trig = 1; @(negedge clk); a_trig = 0;
    @(negedge clk);
    cmp("R10 auto valid", a_rd_valid, 1);
    cmp("R10 auto bank", a_rd_bank, (w + 2 * NB - LAT - X + 1) % NB);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_advance();
    t_single();
    t_full_stall();
    t_auto();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule